// File: doc/BRIEF.md
# Processor Status Register with User I/O

This block is the 16-bit status and control word of a small signal-processing core. The upper part of the word belongs to hardware: four arithmetic flags (negative, overflow, zero, carry) that change only when the arithmetic unit strobes a result, and two bits that follow a pair of external user input pins after synchronization. The lower ten bits are control bits that software writes. These bits set the shift-by-three scaling mode, overflow clamping, the interrupt enable, two user output bits, the two upper address bits for short direct addressing and the pointer loop size.

Software can always read the whole word, and a software write changes only the ten control bits. The control fields are also brought out as separate signals for the datapath, interrupt and addressing logic around the block. The two user output bits go to two port pins in inverted form. This happens only when an external user-output enable is set and both counter/timers are off. In every other case the pins pass an alternate-function value straight through.

Top module: `psr_user_io`

## Requirements
- R1: While reset is asserted, and until the first write, strobe or pin change after reset, `status_q` reads 16'h0000 and every exported control field is zero.
- R2: A cycle with `sw_we` high loads `sw_wdata[9:0]` into `status_q[9:0]`, visible after that rising edge. `sw_wdata[15:10]` is ignored. Bits 9..0 hold their value while `sw_we` is low.
- R3: A cycle with `alu_flag_we` high loads `alu_flags` into `status_q[15:12]`, where bit 15 = negative (`alu_flags[3]`), 14 = overflow (`alu_flags[2]`), 13 = zero (`alu_flags[1]`) and 12 = carry (`alu_flags[0]`). These bits hold while the strobe is low.
- R4: `status_q[11]` follows `user_in[1]` and `status_q[10]` follows `user_in[0]`. A pin change first shows on the SYNC_STAGES+1-th rising edge after it, and not on any earlier edge. Software writes never change these bits.
- R5: A software write and a flag strobe in the same cycle both take effect, each on its own bit range.
- R6: The exported fields decode the live word: `shift3_mode` = bit 9, `ovf_clamp` = bit 8, `irq_enable` = bit 7, `user_out` = bits 6..5, `sdir_msb` = bits 4..3 and `loop_size` = bits 2..0.
- R7: When `uout_en` is 1 and `tmr0_on` and `tmr1_on` are both 0, `port_pins[1]` (port bit 3) = NOT `status_q[6]` and `port_pins[0]` (port bit 2) = NOT `status_q[5]`.
- R8: When that condition is false, `port_pins` equals `alt_port_in` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alu_flag_we | input | 1 | Strobe that loads the arithmetic flags |
| alu_flags | input | 4 | {negative, overflow, zero, carry} |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 16 | Software write word; only bits 9..0 are used |
| user_in | input | 2 | Asynchronous user input pins |
| uout_en | input | 1 | User-output enable from the extension control register |
| tmr0_on | input | 1 | Counter/timer 0 is running |
| tmr1_on | input | 1 | Counter/timer 1 is running |
| alt_port_in | input | 2 | Alternate-function values for port bits 3..2 |
| status_q | output | 16 | Full status word |
| shift3_mode | output | 1 | Shift multiply result right by three |
| ovf_clamp | output | 1 | Clamp at extreme values instead of wrapping |
| irq_enable | output | 1 | Interrupt enable |
| user_out | output | 2 | User output bits {bit 6, bit 5} |
| sdir_msb | output | 2 | Upper address bits for short direct addressing |
| loop_size | output | 3 | Pointer loop size code |
| port_pins | output | 2 | Port bits {3, 2} |

## Verification
The bench builds the block with its default parameters, SYNC_STAGES = 2 and RST_STAGES = 2, and derives the user-input latency of three edges from SYNC_STAGES. With these values it can check that a pin change is absent one edge before its expected arrival and present on that edge. It also waits out the two-edge reset release before it drives any other stimulus. At these values it covers all four gating combinations of the port pins and the same-cycle collision between a write and a flag strobe.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int WORD_W   = 16;
  localparam int FLAG_W   = 4;
  localparam int UIN_W    = 2;
  localparam int CTRL_W   = 10;
  localparam int SDIR_W   = 2;
  localparam int LOOP_W   = 3;
  localparam int UOUT_W   = 2;

  // Bit layout of the word (fixed: surrounding logic decodes it)
  localparam int CTRL_LSB = 0;
  localparam int UIN_LSB  = CTRL_LSB + CTRL_W;
  localparam int FLAG_LSB = UIN_LSB + UIN_W;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zero;
    logic carry;
  } psr_flags_t;

  typedef struct packed {
    logic              shift3;
    logic              clamp;
    logic              irq_en;
    logic [UOUT_W-1:0] uout;
    logic [SDIR_W-1:0] sdir;
    logic [LOOP_W-1:0] loop;
  } psr_ctrl_t;

endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = chain[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= RST_VAL;
      else        chain[s] <= stage_d;
    end
  end

  assign q = chain[STAGES-1];

  if (STAGES >= 2) begin : g_chk
    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      chain[STAGES-1] == $past(chain[STAGES-2])); // R4
  end

endmodule

// File: rtl/psr_regs.sv
module psr_regs
  import psr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alu_we,
  input  psr_flags_t       alu_flags,
  input  logic             sw_we,
  input  psr_ctrl_t        sw_ctrl,
  input  logic [UIN_W-1:0] uin_sync,
  output psr_flags_t       flags_q,
  output logic [UIN_W-1:0] uin_q,
  output psr_ctrl_t        ctrl_q
);

  psr_flags_t flags_d;
  psr_ctrl_t  ctrl_d;
  logic [UIN_W-1:0] uin_d;

  // Next state: each owner updates only its own range
  always_comb begin
    flags_d = flags_q;
    ctrl_d  = ctrl_q;
    uin_d   = uin_sync;
    if (alu_we) flags_d = alu_flags;
    if (sw_we)  ctrl_d  = sw_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ctrl_q  <= '0;
      uin_q   <= '0;
    end else begin
      flags_q <= flags_d;
      ctrl_q  <= ctrl_d;
      uin_q   <= uin_d;
    end
  end

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    alu_we |=> flags_q == $past(alu_flags)); // R3
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_we |=> $stable(flags_q)); // R3
  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> ctrl_q == $past(sw_ctrl)); // R2
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> $stable(ctrl_q)); // R2
  AST_UIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> uin_q == $past(uin_sync)); // R4

endmodule

// File: rtl/psr_port_mux.sv
module psr_port_mux
  import psr_pkg::*;
(
  input  logic              uout_en,
  input  logic              tmr0_on,
  input  logic              tmr1_on,
  input  logic [UOUT_W-1:0] uout,
  input  logic [UOUT_W-1:0] alt_in,
  output logic [UOUT_W-1:0] pins
);

  logic drive_user;

  always_comb begin
    drive_user = uout_en & ~tmr0_on & ~tmr1_on;
  end

  for (genvar i = 0; i < UOUT_W; i++) begin : g_pin
    always_comb begin
      if (drive_user) pins[i] = ~uout[i];
      else            pins[i] = alt_in[i];
    end
  end

endmodule

// File: rtl/psr_user_io.sv
module psr_user_io
  import psr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alu_flag_we,
  input  logic [3:0]  alu_flags,
  input  logic        sw_we,
  input  logic [15:0] sw_wdata,
  input  logic [1:0]  user_in,
  input  logic        uout_en,
  input  logic        tmr0_on,
  input  logic        tmr1_on,
  input  logic [1:0]  alt_port_in,
  output logic [15:0] status_q,
  output logic        shift3_mode,
  output logic        ovf_clamp,
  output logic        irq_enable,
  output logic [1:0]  user_out,
  output logic [1:0]  sdir_msb,
  output logic [2:0]  loop_size,
  output logic [1:0]  port_pins
);

  logic             rst_sync_n;
  logic [UIN_W-1:0] uin_sync;
  psr_flags_t       flags_q;
  psr_ctrl_t        ctrl_q;
  logic [UIN_W-1:0] uin_q;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^sw_wdata[WORD_W-1:CTRL_W];

  // Reset: asserted asynchronously, released on a clock edge
  psr_sync #(.W(1), .STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  psr_sync #(.W(UIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_uin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (user_in),
    .q     (uin_sync)
  );

  psr_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .alu_we    (alu_flag_we),
    .alu_flags (psr_flags_t'(alu_flags)),
    .sw_we     (sw_we),
    .sw_ctrl   (psr_ctrl_t'(sw_wdata[CTRL_W-1:0])),
    .uin_sync  (uin_sync),
    .flags_q   (flags_q),
    .uin_q     (uin_q),
    .ctrl_q    (ctrl_q)
  );

  always_comb begin
    status_q    = {flags_q, uin_q, ctrl_q};
    shift3_mode = ctrl_q.shift3;
    ovf_clamp   = ctrl_q.clamp;
    irq_enable  = ctrl_q.irq_en;
    user_out    = ctrl_q.uout;
    sdir_msb    = ctrl_q.sdir;
    loop_size   = ctrl_q.loop;
  end

  psr_port_mux u_port (
    .uout_en (uout_en),
    .tmr0_on (tmr0_on),
    .tmr1_on (tmr1_on),
    .uout    (ctrl_q.uout),
    .alt_in  (alt_port_in),
    .pins    (port_pins)
  );

  AST_PORT_USER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (uout_en && !tmr0_on && !tmr1_on) |-> port_pins == ~status_q[6:5]); // R7
  AST_PORT_ALT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(uout_en && !tmr0_on && !tmr1_on) |-> port_pins == alt_port_in); // R8
  AST_WRITE_KEEPS_HW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sw_we && !alu_flag_we) |=> status_q[15:12] == $past(status_q[15:12])); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_sync_n |-> status_q == '0); // R1

endmodule

// File: tb/psr_user_io_test.sv
module psr_user_io_test;

  localparam int CLK_PERIOD  = 10;
  localparam int SYNC_STAGES = 2;
  localparam int UIN_LAT     = SYNC_STAGES + 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alu_flag_we;
  logic [3:0]  alu_flags;
  logic        sw_we;
  logic [15:0] sw_wdata;
  logic [1:0]  user_in;
  logic        uout_en, tmr0_on, tmr1_on;
  logic [1:0]  alt_port_in;
  logic [15:0] status_q;
  logic        shift3_mode, ovf_clamp, irq_enable;
  logic [1:0]  user_out, sdir_msb, port_pins;
  logic [2:0]  loop_size;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_user_io #(.SYNC_STAGES(SYNC_STAGES), .RST_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .alu_flag_we(alu_flag_we), .alu_flags(alu_flags),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .user_in(user_in), .uout_en(uout_en),
    .tmr0_on(tmr0_on), .tmr1_on(tmr1_on), .alt_port_in(alt_port_in),
    .status_q(status_q), .shift3_mode(shift3_mode), .ovf_clamp(ovf_clamp),
    .irq_enable(irq_enable), .user_out(user_out), .sdir_msb(sdir_msb),
    .loop_size(loop_size), .port_pins(port_pins)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sw_write(input logic [15:0] w);
    @(negedge clk); sw_we = 1'b1; sw_wdata = w;
    @(negedge clk); sw_we = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 status in reset", status_q, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 status after reset", status_q, 16'h0000);
    check("R1 fields after reset",
          {7'd0, shift3_mode, ovf_clamp, irq_enable, user_out, sdir_msb, loop_size}, 16'h0000);
  endtask

  task automatic t_write;
    sw_write(16'hFFFF);
    check("R2 write all ones keeps hw bits", status_q, 16'h03FF);
    sw_write(16'hFC00 | 16'h0155);
    check("R2 write pattern", status_q, 16'h0155);
    check("R6 fields 0x155",
          {7'd0, shift3_mode, ovf_clamp, irq_enable, user_out, sdir_msb, loop_size}, 16'h0155);
    sw_write(16'h02AA);
    check("R6 fields 0x2AA",
          {7'd0, shift3_mode, ovf_clamp, irq_enable, user_out, sdir_msb, loop_size}, 16'h02AA);
    @(negedge clk); sw_wdata = 16'h0000;
    @(negedge clk);
    check("R2 hold while we low", status_q, 16'h02AA);
  endtask

  task automatic t_alu;
    @(negedge clk); alu_flag_we = 1'b1; alu_flags = 4'b1010;
    @(negedge clk); alu_flag_we = 1'b0; alu_flags = 4'b0101;
    check("R3 flag load", status_q, 16'hA2AA);
    @(negedge clk);
    check("R3 flag hold", status_q, 16'hA2AA);
    sw_write(16'hF000);
    check("R2 write ignores flags", status_q, 16'hA000);
  endtask

  task automatic t_both;
    @(negedge clk);
    alu_flag_we = 1'b1; alu_flags = 4'b0111;
    sw_we = 1'b1; sw_wdata = 16'h0319;
    @(negedge clk);
    alu_flag_we = 1'b0; sw_we = 1'b0;
    check("R5 same-cycle write and strobe", status_q, 16'h7319);
  endtask

  task automatic t_uin;
    logic [15:0] base;
    base = status_q;
    @(negedge clk); user_in = 2'b10;
    repeat (UIN_LAT - 1) @(negedge clk);
    check("R4 not early", status_q, base);
    @(negedge clk);
    check("R4 pin1 arrives", status_q, base | 16'h0800);
    @(negedge clk); user_in = 2'b01;
    repeat (UIN_LAT) @(negedge clk);
    check("R4 pin0 arrives", status_q, (base & 16'hF3FF) | 16'h0400);
    sw_write(16'h0C00);
    check("R4 write ignores pins", status_q, 16'h7400);
    @(negedge clk); user_in = 2'b00;
    repeat (UIN_LAT) @(negedge clk);
    check("R4 pins low", status_q, 16'h7000);
  endtask

  task automatic t_port;
    sw_write(16'h0040);             // user out bit6=1, bit5=0
    alt_port_in = 2'b01;
    uout_en = 1'b1; tmr0_on = 1'b0; tmr1_on = 1'b0;
    #1 check("R7 inverted user out", {14'd0, port_pins}, 16'h0001);
    sw_write(16'h0020);             // bit6=0, bit5=1
    #1 check("R7 inverted user out 2", {14'd0, port_pins}, 16'h0002);
    tmr0_on = 1'b1; alt_port_in = 2'b11;
    #1 check("R8 timer0 on gives alt", {14'd0, port_pins}, 16'h0003);
    tmr0_on = 1'b0; tmr1_on = 1'b1; alt_port_in = 2'b00;
    #1 check("R8 timer1 on gives alt", {14'd0, port_pins}, 16'h0000);
    tmr1_on = 1'b0; uout_en = 1'b0; alt_port_in = 2'b10;
    #1 check("R8 enable off gives alt", {14'd0, port_pins}, 16'h0002);
    uout_en = 1'b1;
    #1 check("R7 re-enabled", {14'd0, port_pins}, 16'h0002);
    sw_write(16'h0000);
    #1 check("R7 both outs zero", {14'd0, port_pins}, 16'h0003);
  endtask

  initial begin
    alu_flag_we = 1'b0; alu_flags = '0; sw_we = 1'b0; sw_wdata = '0;
    user_in = '0; uout_en = 1'b0; tmr0_on = 1'b0; tmr1_on = 1'b0;
    alt_port_in = '0; rst_n = 1'b0;
    t_reset();
    t_write();
    t_alu();
    t_both();
    t_uin();
    t_port();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule